// File: doc/BRIEF.md
# Coincident-Select Synchronous Word RAM

This block is a synchronous single-port memory of 1024 words. No single 1-of-1024 decoder selects a word. The address is cut into a row half and a column half, and each half drives its own small one-hot decoder. The storage is laid out as a square grid of words. A word takes part in an access only where its row line and its column line are both active. The grid therefore needs 64 decoder outputs in place of 1024.

The port has an address bus, a write-data bus, a registered read-data bus, and separate write-enable and read-enable inputs. A write lands on the rising clock edge while write-enable is high. A read samples the addressed word on the edge where read-enable is high, and the word is presented one cycle later. The output holds its value between reads.

Top module: `xy_sel_ram`

## Requirements
- R1: The memory holds 2^ADDR_W words of DATA_W bits (1024 x 8 by default). A word presented on `wr_data` is stored at `addr` on a rising clock edge where `wr_en` is 1.
- R2: A synchronous active-high `rst` clears `rd_data` to 0 on the next edge. Reset does not alter the stored words.
- R3: The row index is `addr[ADDR_W-1:ADDR_W/2]` (bits 9:5 by default) and the column index is `addr[ADDR_W/2-1:0]` (bits 4:0). Each index is decoded to a one-hot vector of 32 lines.
- R4: A write changes only the word whose row line and column line are both active. Words that share just the row, or just the column, keep their contents.
- R5: When `rd_en` is 1 at an edge, `rd_data` shows the word stored at `addr` from that edge onward, which is one cycle later.
- R6: When `wr_en` and `rd_en` are both 1 at the same edge, the write takes place and `rd_data` returns the contents the word held before that write.
- R7: While `rd_en` is 0, `rd_data` keeps its last value, including during writes.
- R8: While `wr_en` is 0, no stored word changes, whatever `addr` and `wr_data` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset of the read register |
| addr | input | ADDR_W | Word address; upper half is the row, lower half is the column |
| wr_en | input | 1 | Write strobe |
| wr_data | input | DATA_W | Data to store |
| rd_en | input | 1 | Read strobe |
| rd_data | output | DATA_W | Registered read data |

## Verification
The bench builds the block with the defaults ADDR_W=10 and DATA_W=8. These give two 5-bit halves and a 32 x 32 grid that is small enough to sweep completely. With these values every row line and every column line is exercised in every combination, and the corner addresses that share a row or a column with a written word can be checked for disturbance. The 8-bit data lets each address carry a value derived from the address, so any aliasing between two grid crossings shows up as a wrong word.

// File: rtl/xy_sel_pkg.sv
package xy_sel_pkg;
  localparam int unsigned XY_ADDR_W_DEFAULT = 10;
  localparam int unsigned XY_DATA_W_DEFAULT = 8;

  // Width of the column half; the row half takes the remaining bits.
  function automatic int unsigned col_bits(input int unsigned aw);
    return aw / 2;
  endfunction
endpackage

// File: rtl/xy_line_dec.sv
module xy_line_dec #(
  parameter int unsigned IN_W = 5,
  localparam int unsigned LINES = 1 << IN_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IN_W-1:0]  code,
  output logic [LINES-1:0] lines
);
  // One AND term per output line.
  for (genvar i = 0; i < LINES; i++) begin : g_line
    assign lines[i] = (code == IN_W'(i));
  end

  // R3: exactly one line, and it is the one named by the code.
  a_r3_line_onehot: assert property (@(posedge clk) disable iff (rst)
    ($countones(lines) == 1) && lines[code]);
endmodule

// File: rtl/xy_grid.sv
module xy_grid #(
  parameter int unsigned ROW_W  = 5,
  parameter int unsigned COL_W  = 5,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned ROWS  = 1 << ROW_W,
  localparam int unsigned COLS  = 1 << COL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ROWS-1:0]   row_sel,
  input  logic [COLS-1:0]   col_sel,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_word
);
  logic [ROWS*COLS-1:0] cell_wr;
  logic [DATA_W-1:0]    col_gated [ROWS][COLS];
  logic [DATA_W-1:0]    row_word  [ROWS];

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      logic [DATA_W-1:0] q;
      // Coincident select: row line AND column line AND strobe.
      assign cell_wr[r*COLS + c] = wr_en & row_sel[r] & col_sel[c];
      always_ff @(posedge clk) begin
        if (cell_wr[r*COLS + c]) q <= wr_data;
      end
      assign col_gated[r][c] = q & {DATA_W{col_sel[c]}};
    end
  end

  // Stage 1: within each row, the column line picks one word.
  always_comb begin
    for (int r = 0; r < ROWS; r++) begin
      row_word[r] = '0;
      for (int c = 0; c < COLS; c++) row_word[r] = row_word[r] | col_gated[r][c];
    end
  end

  // Stage 2: the row line picks one row result.
  always_comb begin
    rd_word = '0;
    for (int r = 0; r < ROWS; r++) rd_word = rd_word | (row_word[r] & {DATA_W{row_sel[r]}});
  end

  // R4 / R8: at most one word is strobed, and exactly one while writing.
  a_r4_single_cell: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> ($countones(cell_wr) == 1));
  a_r8_no_strobe: assert property (@(posedge clk) disable iff (rst)
    !wr_en |-> (cell_wr == '0));
  // R1: a written word reads back through the select path on the next cycle.
  a_r1_write_lands: assert property (@(posedge clk) disable iff (rst)
    ($past(wr_en) && (row_sel == $past(row_sel)) && (col_sel == $past(col_sel)))
      |-> (rd_word == $past(wr_data)));
endmodule

// File: rtl/xy_sel_ram.sv
module xy_sel_ram #(
  parameter int unsigned ADDR_W = xy_sel_pkg::XY_ADDR_W_DEFAULT,
  parameter int unsigned DATA_W = xy_sel_pkg::XY_DATA_W_DEFAULT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data
);
  localparam int unsigned COL_W = xy_sel_pkg::col_bits(ADDR_W);
  localparam int unsigned ROW_W = ADDR_W - COL_W;
  localparam int unsigned ROWS  = 1 << ROW_W;
  localparam int unsigned COLS  = 1 << COL_W;

  logic [ROWS-1:0]   row_sel;
  logic [COLS-1:0]   col_sel;
  logic [DATA_W-1:0] rd_word;

  xy_line_dec #(.IN_W(ROW_W)) u_row_dec (
    .clk(clk), .rst(rst), .code(addr[ADDR_W-1:COL_W]), .lines(row_sel));

  xy_line_dec #(.IN_W(COL_W)) u_col_dec (
    .clk(clk), .rst(rst), .code(addr[COL_W-1:0]), .lines(col_sel));

  xy_grid #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W)) u_grid (
    .clk(clk), .rst(rst), .row_sel(row_sel), .col_sel(col_sel),
    .wr_en(wr_en), .wr_data(wr_data), .rd_word(rd_word));

  // Read register: samples the pre-write word, so a same-edge write
  // returns old contents (R6).
  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= rd_word;
  end

  a_r2_reset_clears: assert property (@(posedge clk)
    rst |=> (rd_data == '0));
  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));
endmodule

// File: tb/xy_sel_ram_tb.sv
module xy_sel_ram_tb;
  localparam int unsigned AW = 10;
  localparam int unsigned DW = 8;

  logic          clk = 1'b0;
  logic          rst;
  logic [AW-1:0] addr;
  logic          wr_en;
  logic [DW-1:0] wr_data;
  logic          rd_en;
  logic [DW-1:0] rd_data;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  xy_sel_ram #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en),
    .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data));

  // Vector fields: req(4) we(1) re(1) addr(10) wdata(8) chk(1) exp(8)
  localparam int NV = 21;
  localparam logic [32:0] VEC [NV] = '{
    {4'd1, 1'b1, 1'b0, 10'h000, 8'h11, 1'b0, 8'h00},  // R1 write corner
    {4'd4, 1'b1, 1'b0, 10'h021, 8'h22, 1'b0, 8'h00},  // R4 row1 col1
    {4'd4, 1'b1, 1'b0, 10'h001, 8'h33, 1'b0, 8'h00},  // R4 same column
    {4'd4, 1'b1, 1'b0, 10'h020, 8'h44, 1'b0, 8'h00},  // R4 same row
    {4'd3, 1'b1, 1'b0, 10'h3FF, 8'h55, 1'b0, 8'h00},  // R3 top corner
    {4'd3, 1'b1, 1'b0, 10'h3E0, 8'h66, 1'b0, 8'h00},  // R3 last row col0
    {4'd3, 1'b1, 1'b0, 10'h01F, 8'h77, 1'b0, 8'h00},  // R3 row0 last col
    {4'd5, 1'b0, 1'b1, 10'h000, 8'h00, 1'b1, 8'h11},  // R5
    {4'd4, 1'b0, 1'b1, 10'h021, 8'h00, 1'b1, 8'h22},  // R4
    {4'd4, 1'b0, 1'b1, 10'h001, 8'h00, 1'b1, 8'h33},  // R4
    {4'd4, 1'b0, 1'b1, 10'h020, 8'h00, 1'b1, 8'h44},  // R4
    {4'd3, 1'b0, 1'b1, 10'h3FF, 8'h00, 1'b1, 8'h55},  // R3
    {4'd3, 1'b0, 1'b1, 10'h3E0, 8'h00, 1'b1, 8'h66},  // R3
    {4'd3, 1'b0, 1'b1, 10'h01F, 8'h00, 1'b1, 8'h77},  // R3
    {4'd6, 1'b1, 1'b1, 10'h021, 8'h99, 1'b1, 8'h22},  // R6 old data
    {4'd6, 1'b0, 1'b1, 10'h021, 8'h00, 1'b1, 8'h99},  // R6 new data landed
    {4'd7, 1'b0, 1'b0, 10'h000, 8'h00, 1'b1, 8'h99},  // R7 hold
    {4'd8, 1'b0, 1'b0, 10'h001, 8'hFF, 1'b1, 8'h99},  // R8 we low, R7
    {4'd8, 1'b0, 1'b1, 10'h001, 8'h00, 1'b1, 8'h33},  // R8 untouched
    {4'd7, 1'b1, 1'b0, 10'h3FF, 8'hAA, 1'b1, 8'h33},  // R7 hold during write
    {4'd1, 1'b0, 1'b1, 10'h3FF, 8'h00, 1'b1, 8'hAA}   // R1
  };

  function automatic logic [DW-1:0] pat(input int a);
    return DW'(a * 7 + (a >> 3) + 3);
  endfunction

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic we, input logic re, input logic [AW-1:0] a, input logic [DW-1:0] d);
    wr_en = we; rd_en = re; addr = a; wr_data = d;
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=<150000 cycles", cycles);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; wr_en = 0; rd_en = 0; addr = '0; wr_data = '0;
    @(negedge clk); @(negedge clk);
    check("R2 reset value", rd_data, 8'h00);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][28], VEC[i][27], VEC[i][26:17], VEC[i][16:9]);
      if (VEC[i][8])
        check($sformatf("R%0d vector %0d", VEC[i][32:29], i), rd_data, VEC[i][7:0]);
    end

    // R2: reset clears the output but keeps stored words.
    rd_en = 1'b1; addr = 10'h3FF; @(negedge clk);
    rst = 1'b1; rd_en = 1'b0; @(negedge clk);
    check("R2 cleared", rd_data, 8'h00);
    rst = 1'b0;
    step(1'b0, 1'b1, 10'h3FF, 8'h00);
    check("R2 contents kept", rd_data, 8'hAA);

    // R1 / R3 / R4: fill every crossing, then read all back.
    for (int a = 0; a < (1 << AW); a++) step(1'b1, 1'b0, AW'(a), pat(a));
    for (int a = 0; a < (1 << AW); a++) begin
      step(1'b0, 1'b1, AW'(a), 8'h00);
      check($sformatf("R4 sweep addr %0h", a), rd_data, pat(a));
    end

    // R6 at a corner crossing, then R5 readback.
    step(1'b1, 1'b1, 10'h3E0, 8'h5A);
    check("R6 corner old", rd_data, pat(10'h3E0));
    step(1'b0, 1'b1, 10'h3E0, 8'h00);
    check("R5 corner new", rd_data, 8'h5A);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule